// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds one priority value per interrupt for an interrupt distributor. Every interrupt has an 8-bit priority slot. Four neighbouring interrupts share one 32-bit word, so interrupt `n` lives at byte address `n`. Software reaches the bank over a plain register bus. The bus has a byte address, 32-bit write data, four byte-write strobes, a read enable and registered read data. A write can cover the whole word or a single byte lane.

Only the upper `PRIO_BITS` bits of each slot are stored. The lower bits always read as zero, which gives software a simple way to probe how many bits exist: write all ones and read the word back. Word indices at or past `NUM_IRQ/4` read zero and ignore writes.

A separate combinational lookup port gives the stored priority of any interrupt number to a downstream arbiter.

Top module: `irq_prio_bank`

## Requirements
- R1: After `rst_ni` is low, every implemented priority slot reads zero, on both the bus and the lookup port.
- R2: Each slot keeps only its top `PRIO_BITS` bits (default 5). The lower `8-PRIO_BITS` bits read zero. Writing 0xFFFFFFFF to a word reads back the same mask in all four lanes (0xF8F8F8F8 by default).
- R3: Interrupt `n` occupies bits `8*(n%4)+7 : 8*(n%4)` of the word at byte address `4*(n/4)`.
- R4: Write strobe bit `k` (bit 0 = bits 7:0) updates only lane `k`. Lanes whose strobe is low keep their value, so a single-byte write changes one interrupt only.
- R5: Word selection uses address bits `ADDR_W-1:2`; bits 1:0 are ignored. A word index at or above `NUM_IRQ/4` reads zero, and a write to it changes no stored slot.
- R6: The last implemented word, holding interrupts `NUM_IRQ-4` to `NUM_IRQ-1`, is fully writable and readable.
- R7: `rdata_o` loads on the clock edge where `rd_en_i` is high and holds while `rd_en_i` is low. A read in the same cycle as a write to the same word returns the value from before the write.
- R8: `lk_prio_o` gives, with no clock delay, the stored 8-bit priority of interrupt `lk_irq_i`. Its low bits are zero. It is zero for any `lk_irq_i >= NUM_IRQ`.
- R9: A full-word write followed by a read returns the written data ANDed with the implemented mask in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte write strobes; a write happens when any bit is set |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 32 | Registered read data |
| lk_irq_i | input | IRQ_W | Interrupt number to look up |
| lk_prio_o | output | 8 | Priority of `lk_irq_i` |

## Verification
Some internal faults show up on the very next read of the affected word, one cycle after the read request:
- a stuck or wrongly enabled lane flop;
- a write-enable decode that hits the wrong word;
- an out-of-range write that wraps onto a low word.

The lookup port shows the same corrupted slot with no delay. So a write with a distinct pattern in each lane, followed by a read and a lookup of each lane, catches lane swaps and leaks between lanes.

A read register that reloads when it should hold shows up as a changed `rdata_o` during idle cycles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  function automatic logic [LANE_W-1:0] lane_mask(input int bits);
    logic [LANE_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANE_W; i++)
      if (i >= LANE_W - bits) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_prio_word.sv
module irq_prio_word
  import irq_prio_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int LO_W = LANE_W - PRIO_BITS;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = l * LANE_W + LANE_W - 1;
    logic [PRIO_BITS-1:0] prio_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 prio_q <= '0;
      else if (we_i && strb_i[l])  prio_q <= wdata_i[HI -: PRIO_BITS];
    end

    assign word_o[HI -: PRIO_BITS] = prio_q;
    if (LO_W > 0) begin : g_pad
      assign word_o[l*LANE_W +: LO_W] = '0;
    end

    // R4: an unstrobed lane holds
    p_lane_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && strb_i[l]) |=> $stable(word_o[HI -: LANE_W]));
  end
endmodule

// File: rtl/irq_prio_rdport.sv
module irq_prio_rdport
  import irq_prio_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WIDX_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [WIDX_W-1:0]             widx_i,
  input  logic [NUM_WORDS*DATA_W-1:0]   words_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0] sel;

  // OR-mux: an index with no matching word yields zero
  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (32'(widx_i) == w) sel = sel | words_i[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= sel;
  end
endmodule

// File: rtl/irq_prio_lookup.sv
module irq_prio_lookup
  import irq_prio_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int IRQ_W     = 10
) (
  input  logic [IRQ_W-1:0]              irq_i,
  input  logic [NUM_WORDS*DATA_W-1:0]   words_i,
  output logic [LANE_W-1:0]             prio_o
);
  logic [DATA_W-1:0] word;
  logic [1:0]        lane;

  assign lane = irq_i[1:0];

  always_comb begin
    word = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (32'(irq_i[IRQ_W-1:2]) == w) word = word | words_i[w*DATA_W +: DATA_W];
  end

  assign prio_o = word[lane*LANE_W +: LANE_W];
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5,
  parameter int ADDR_W    = 10,
  parameter int IRQ_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  input  logic [IRQ_W-1:0]  lk_irq_i,
  output logic [7:0]        lk_prio_o
);
  localparam int NUM_WORDS = NUM_IRQ / LANES;
  localparam int WIDX_W    = ADDR_W - 2;
  localparam logic [DATA_W-1:0] MASK32 = {LANES{lane_mask(PRIO_BITS)}};

  logic [WIDX_W-1:0]           widx;
  logic                        wr_any;
  logic [NUM_WORDS*DATA_W-1:0] words;
  logic                        unused_addr_lo;

  assign widx           = addr_i[ADDR_W-1:2];
  assign wr_any         = |wstrb_i;
  assign unused_addr_lo = ^addr_i[1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic we;
    assign we = wr_any && (32'(widx) == w);
    irq_prio_word #(.PRIO_BITS(PRIO_BITS)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .strb_i  (wstrb_i),
      .wdata_i (wdata_i),
      .word_o  (words[w*DATA_W +: DATA_W])
    );
  end

  irq_prio_rdport #(.NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_rdport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .widx_i  (widx),
    .words_i (words),
    .rdata_o (rdata_o)
  );

  irq_prio_lookup #(.NUM_WORDS(NUM_WORDS), .IRQ_W(IRQ_W)) u_lookup (
    .irq_i   (lk_irq_i),
    .words_i (words),
    .prio_o  (lk_prio_o)
  );

  p_rd_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~MASK32) == '0);

  p_rd_oob_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (32'(widx) >= NUM_WORDS)) |=> rdata_o == '0);

  p_rd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_lk_oob_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lk_irq_i) >= NUM_IRQ) |-> lk_prio_o == '0);
endmodule

// File: tb/irq_prio_bank_tb_top.sv
module irq_prio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 64;
  localparam int PRIO_BITS  = 5;
  localparam int ADDR_W     = 10;
  localparam int IRQ_W      = 10;
  localparam int NUM_WORDS  = NUM_IRQ / 4;
  localparam logic [7:0]  LANE_M = 8'hFF << (8 - PRIO_BITS);
  localparam logic [31:0] WORD_M = {4{LANE_M}};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [3:0]        wstrb_i = '0;
  logic              rd_en_i = 1'b0;
  logic [31:0]       rdata_o;
  logic [IRQ_W-1:0]  lk_irq_i = '0;
  logic [7:0]        lk_prio_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] model [NUM_WORDS];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W),
                  .IRQ_W(IRQ_W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int baddr, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk_i);
    addr_i = ADDR_W'(baddr); wdata_i = d; wstrb_i = s;
    @(negedge clk_i);
    wstrb_i = '0;
    if (baddr / 4 < NUM_WORDS)
      for (int l = 0; l < 4; l++)
        if (s[l]) model[baddr/4][l*8 +: 8] = d[l*8 +: 8] & LANE_M;
  endtask

  task automatic bus_rd(input int baddr, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = ADDR_W'(baddr); rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic lookup(input int irq, output logic [7:0] p);
    lk_irq_i = IRQ_W'(irq);
    #1;
    p = lk_prio_o;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [7:0] p;
    bus_rd(0, d);               chk("R1 word0", d, 32'h0);
    bus_rd(NUM_IRQ - 4, d);     chk("R1 last word", d, 32'h0);
    lookup(5, p);               chk("R1 lookup", 32'(p), 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d; logic [7:0] p;
    bus_wr(32, 32'hFFFF_FFFF, 4'hF);
    bus_rd(32, d);              chk("R2 all-ones mask", d, 32'hF8F8_F8F8);
    lookup(33, p);              chk("R8 lookup irq33", 32'(p), 32'hF8);
  endtask

  task automatic t_pattern();
    logic [31:0] d; logic [7:0] p;
    bus_wr(32, 32'hFF7F_BF3F, 4'hF);
    bus_rd(32, d);              chk("R9 masked readback", d, 32'hF878_B838);
    lookup(32, p);              chk("R3 irq32 lane0", 32'(p), 32'h38);
    lookup(34, p);              chk("R3 irq34 lane2", 32'(p), 32'h78);
    lookup(35, p);              chk("R3 irq35 lane3", 32'(p), 32'hF8);
  endtask

  task automatic t_byte();
    logic [31:0] d;
    bus_wr(34, 32'h001F_0000, 4'b0100);
    bus_rd(33, d);              chk("R4 byte write lane2 only", d, 32'hF818_B838);
    chk("R5 low addr bits ignored", d, model[8]);
  endtask

  task automatic t_last();
    logic [31:0] d; logic [7:0] p;
    bus_wr(NUM_IRQ - 4, 32'hA5C3_7E81, 4'hF);
    bus_rd(NUM_IRQ - 4, d);     chk("R6 last word", d, 32'hA0C0_7880);
    lookup(NUM_IRQ - 1, p);     chk("R6 last irq lookup", 32'(p), 32'hA0);
  endtask

  task automatic t_oob();
    logic [31:0] d; logic [7:0] p;
    bus_wr(NUM_IRQ, 32'hFFFF_FFFF, 4'hF);
    bus_wr(1020, 32'hFFFF_FFFF, 4'hF);
    bus_rd(NUM_IRQ, d);         chk("R5 oob read zero", d, 32'h0);
    bus_rd(1020, d);            chk("R5 top oob read zero", d, 32'h0);
    bus_rd(NUM_IRQ - 4, d);     chk("R5 oob write no effect last", d, model[NUM_WORDS-1]);
    bus_rd(0, d);               chk("R5 oob write no alias word0", d, 32'h0);
    lookup(NUM_IRQ, p);         chk("R8 oob lookup", 32'(p), 32'h0);
    lookup(1000, p);            chk("R8 far oob lookup", 32'(p), 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] d;
    bus_rd(32, d);
    repeat (3) @(negedge clk_i);
    chk("R7 rdata holds", rdata_o, 32'hF818_B838);
    @(negedge clk_i);
    addr_i = ADDR_W'(32); wdata_i = 32'h1122_3344; wstrb_i = 4'hF; rd_en_i = 1'b1;
    @(negedge clk_i);
    wstrb_i = '0; rd_en_i = 1'b0;
    model[8] = 32'h1122_3344 & WORD_M;
    chk("R7 same-cycle read old value", rdata_o, 32'hF818_B838);
    bus_rd(32, d);              chk("R9 new value", d, 32'h1020_3040);
  endtask

  initial begin
    for (int w = 0; w < NUM_WORDS; w++) model[w] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_mask();
    t_pattern();
    t_byte();
    t_last();
    t_oob();
    t_read_timing();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule